// File: doc/BRIEF.md
# NMI and Reset-Request Event Flag Unit

This block watches two event sources: an external non-maskable interrupt pin and a reset-request line. It records their events in sticky flags inside one 32-bit status word on a simple register bus. Each source has a status flag, set by every detected event, and an overrun flag, set when an event arrives while the status flag is still set. Software clears a flag by writing 1 to its bit. Writing 0 to a bit has no effect, so one flag can be cleared without disturbing the others.

Every source drives an interrupt request and a wakeup request. Both follow the source's pending condition, which is its status flag OR its overrun flag. A destination-select input gates the interrupt request, and a wakeup-enable input gates the wakeup request. The flags are captured whatever the routing is, so an event is recorded even when it raises no request. The pin source passes through a synchronizer. The reset-request line is taken as synchronous.

Top module: `nmi_flag_unit`

## Requirements
- R1: After reset, every flag is 0, all four request outputs are low and the status word reads 0x0000_0000.
- R2: A rising edge on `nmi_pin` sets the NMI status flag (bit 0). The flag is visible 3 clock edges after the edge that first samples the pin high. Holding the pin high produces only one event.
- R3: An NMI event that arrives while bit 0 is set also sets the NMI overrun flag (bit 1).
- R4: A bus write to offset 0x00 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: When an event and a write-1 clear hit the same status flag in the same cycle, the flag ends up set. If the flag was already set, the overrun flag is set too.
- R6: `nmi_irq` is high exactly when (bit 0 OR bit 1) is set and `nmi_route` is not 2'b11 (2'b11 means no destination). `nmi_wake` is high exactly when (bit 0 OR bit 1) is set and `nmi_wake_en` is 1. Flags are set even with route 2'b11 and wake enable 0.
- R7: After the status flag is cleared, a source's requests stay asserted while its overrun flag remains set.
- R8: A rising edge on `rstreq_in` sets bit 16 on the next clock edge. A further edge while bit 16 is set sets bit 17. `rstreq_irq` and `rstreq_wake` are gated by `rstreq_route` and `rstreq_wake_en` under the rules of R6.
- R9: Bits other than 0, 1, 16 and 17 always read 0, and writes to them have no effect.
- R10: A bus access whose word address is not 0x00 asserts `bus_err` in the same cycle, returns read data 0 and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Asynchronous NMI pin level |
| rstreq_in | input | 1 | Synchronous reset-request level |
| nmi_route | input | 2 | NMI destination select, 2'b11 = none |
| nmi_wake_en | input | 1 | NMI wakeup enable |
| rstreq_route | input | 2 | Reset-request destination select, 2'b11 = none |
| rstreq_wake_en | input | 1 | Reset-request wakeup enable |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data (1 clears a flag) |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Transfer error for an unmapped offset |
| nmi_irq | output | 1 | NMI interrupt request |
| nmi_wake | output | 1 | NMI wakeup request |
| rstreq_irq | output | 1 | Reset-request interrupt request |
| rstreq_wake | output | 1 | Reset-request wakeup request |

## Verification
A flag register stuck at 0 or at 1 shows in two places: the read-back word and the gated request lines. The read-back shows it in the same cycle, and the request lines show it as soon as the routing allows. A wrong overrun decision, either a missed capture or a clear that wins over a new event, appears one cycle after the event. It shows first as a missing bit 1 or bit 17, and then as a request that drops when the status bit is cleared. A mistake in the synchronizer depth moves the first visible flag by whole cycles, so the edge timing is checked cycle by cycle.

// File: rtl/nmi_flag_pkg.sv
package nmi_flag_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      ROUTE_D0   = 2'b00,
      ROUTE_D1   = 2'b01,
      ROUTE_D2   = 2'b10,
      ROUTE_NONE = 2'b11
   } route_e;

   typedef struct packed {
      logic ovr;
      logic stat;
   } flag_pair_t;
endpackage

// File: rtl/nmi_edge_sync.sv
module nmi_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   output logic evt_pulse
);
   logic sync_lvl;
   logic prev_q;

   if (STAGES < 0) begin : g_bad_stages
      $error("nmi_edge_sync: STAGES must be >= 0");
   end

   if (STAGES == 0) begin : g_direct
      assign sync_lvl = lvl_in;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= lvl_in;
            for (int i = 1; i < STAGES; i++) begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end
      assign sync_lvl = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_lvl;
   end

   assign evt_pulse = sync_lvl & ~prev_q;
endmodule

// File: rtl/nmi_src_flags.sv
module nmi_src_flags
   import nmi_flag_pkg::*;
#(
   parameter bit HAS_OVR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt,
   input  logic       clr_stat,
   input  logic       clr_ovr,
   output flag_pair_t flags,
   output logic       pend
);
   logic stat_q;
   logic ovr_q;

   // a new event takes priority over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q <= 1'b0;
      else if (evt)      stat_q <= 1'b1;
      else if (clr_stat) stat_q <= 1'b0;
   end

   if (HAS_OVR) begin : g_ovr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              ovr_q <= 1'b0;
         else if (evt && stat_q)  ovr_q <= 1'b1;
         else if (clr_ovr)        ovr_q <= 1'b0;
      end
   end else begin : g_no_ovr
      assign ovr_q = 1'b0;
      logic unused_clr;
      assign unused_clr = clr_ovr;
   end

   assign flags.stat = stat_q;
   assign flags.ovr  = ovr_q;
   assign pend       = stat_q | ovr_q;
endmodule

// File: rtl/nmi_req_gate.sv
module nmi_req_gate
   import nmi_flag_pkg::*;
(
   input  logic       pend,
   input  logic [1:0] route,
   input  logic       wake_en,
   output logic       irq,
   output logic       wake
);
   route_e route_sel;
   assign route_sel = route_e'(route);
   assign irq  = pend && (route_sel != ROUTE_NONE);
   assign wake = pend && wake_en;
endmodule

// File: rtl/nmi_reg_port.sv
module nmi_reg_port #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int REG_OFS = 0,
   parameter logic [DATA_W-1:0] IMPL_MASK = '0
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] flag_word,
   output logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("nmi_reg_port: ADDR_W must be >= 3");
   end
   if (REG_OFS % 4 != 0) begin : g_bad_ofs
      $error("nmi_reg_port: REG_OFS must be word aligned");
   end

   logic hit;
   assign hit = (bus_addr[ADDR_W-1:2] == OFS[ADDR_W-1:2]);

   always_comb begin
      clr_mask  = '0;
      bus_rdata = '0;
      bus_err   = 1'b0;
      if (bus_sel) begin
         if (!hit) begin
            bus_err = 1'b1;
         end else if (bus_wr) begin
            clr_mask = bus_wdata & IMPL_MASK;
         end else begin
            bus_rdata = flag_word & IMPL_MASK;
         end
      end
   end
endmodule

// File: rtl/nmi_flag_unit.sv
module nmi_flag_unit
   import nmi_flag_pkg::*;
#(
   parameter int ADDR_W          = 8,
   parameter int REG_OFS         = 0,
   parameter int SRC_STRIDE      = 16,
   parameter int NMI_SYNC_STAGES = 2,
   parameter int RQ_SYNC_STAGES  = 0,
   parameter bit RQ_HAS_OVR      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_pin,
   input  logic              rstreq_in,
   input  logic [1:0]        nmi_route,
   input  logic              nmi_wake_en,
   input  logic [1:0]        rstreq_route,
   input  logic              rstreq_wake_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   output logic              nmi_irq,
   output logic              nmi_wake,
   output logic              rstreq_irq,
   output logic              rstreq_wake
);
   localparam int NSRC = 2;

   function automatic logic [WORD_W-1:0] impl_mask_f();
      logic [WORD_W-1:0] m;
      m = '0;
      m[0] = 1'b1;
      m[1] = 1'b1;
      m[SRC_STRIDE]   = 1'b1;
      m[SRC_STRIDE+1] = RQ_HAS_OVR;
      return m;
   endfunction

   localparam logic [WORD_W-1:0] IMPL_MASK = impl_mask_f();

   if (SRC_STRIDE < 2 || SRC_STRIDE + 2 > WORD_W) begin : g_bad_stride
      $error("nmi_flag_unit: SRC_STRIDE out of range");
   end

   logic [NSRC-1:0]       src_lvl;
   logic [NSRC-1:0][1:0]  src_route;
   logic [NSRC-1:0]       src_wake_en;
   logic [NSRC-1:0]       src_irq;
   logic [NSRC-1:0]       src_wake;
   logic [WORD_W-1:0]     flag_word;
   logic [WORD_W-1:0]     clr_mask;

   assign src_lvl     = {rstreq_in, nmi_pin};
   assign src_route   = {rstreq_route, nmi_route};
   assign src_wake_en = {rstreq_wake_en, nmi_wake_en};

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int BASE   = s * SRC_STRIDE;
      localparam int STAGES = (s == 0) ? NMI_SYNC_STAGES : RQ_SYNC_STAGES;
      localparam bit OVR    = (s == 0) ? 1'b1 : RQ_HAS_OVR;

      logic       evt;
      logic       pend;
      flag_pair_t flags;

      nmi_edge_sync #(.STAGES(STAGES)) u_sync (
         .clk       (clk),
         .rst_n     (rst_n),
         .lvl_in    (src_lvl[s]),
         .evt_pulse (evt)
      );

      nmi_src_flags #(.HAS_OVR(OVR)) u_flags (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt),
         .clr_stat (clr_mask[BASE]),
         .clr_ovr  (clr_mask[BASE+1]),
         .flags    (flags),
         .pend     (pend)
      );

      nmi_req_gate u_gate (
         .pend    (pend),
         .route   (src_route[s]),
         .wake_en (src_wake_en[s]),
         .irq     (src_irq[s]),
         .wake    (src_wake[s])
      );
   end

   always_comb begin
      flag_word = '0;
      flag_word[0]              = g_src[0].flags.stat;
      flag_word[1]              = g_src[0].flags.ovr;
      flag_word[SRC_STRIDE]     = g_src[1].flags.stat;
      flag_word[SRC_STRIDE + 1] = g_src[1].flags.ovr;
   end

   nmi_reg_port #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (WORD_W),
      .REG_OFS   (REG_OFS),
      .IMPL_MASK (IMPL_MASK)
   ) u_port (
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .flag_word (flag_word),
      .clr_mask  (clr_mask),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err)
   );

   assign nmi_irq     = src_irq[0];
   assign nmi_wake    = src_wake[0];
   assign rstreq_irq  = src_irq[1];
   assign rstreq_wake = src_wake[1];
endmodule

// File: rtl/nmi_flag_unit_chk.sv
module nmi_flag_unit_chk #(
   parameter int ADDR_W     = 8,
   parameter int REG_OFS    = 0,
   parameter int SRC_STRIDE = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       flag_word,
   input logic [1:0]        nmi_route,
   input logic              nmi_wake_en,
   input logic [1:0]        rstreq_route,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              bus_err,
   input logic              nmi_irq,
   input logic              nmi_wake,
   input logic              rstreq_irq
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);
   logic [31:0] used_bits;
   logic        addr_ok;
   logic        wr_ok;

   always_comb begin
      used_bits = '0;
      used_bits[0] = 1'b1;
      used_bits[1] = 1'b1;
      used_bits[SRC_STRIDE] = 1'b1;
      used_bits[SRC_STRIDE+1] = 1'b1;
   end

   assign addr_ok = (bus_addr[ADDR_W-1:2] == OFS[ADDR_W-1:2]);
   assign wr_ok   = bus_sel && bus_wr && addr_ok;

   a_r3_nmi_ovr_needs_stat: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_word[1]) |-> $past(flag_word[0]));

   a_r8_rq_ovr_needs_stat: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_word[SRC_STRIDE+1]) |-> $past(flag_word[SRC_STRIDE]));

   a_r4_stat_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_word[0]) |-> $past(wr_ok && bus_wdata[0]));

   a_r4_ovr_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_word[1]) |-> $past(wr_ok && bus_wdata[1]));

   a_r7_irq_held_by_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_word[1] && nmi_route != 2'b11) |-> nmi_irq);

   a_r6_no_irq_when_none: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_route == 2'b11) |-> !nmi_irq);

   a_r6_wake_follows_pend: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_wake == ((flag_word[0] || flag_word[1]) && nmi_wake_en));

   a_r8_rq_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (rstreq_route == 2'b11) |-> !rstreq_irq);

   a_r9_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~used_bits) == 32'h0);

   a_r10_miss_gives_err: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !addr_ok) |-> (bus_err && bus_rdata == 32'h0));

   a_r10_no_err_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ok |-> !bus_err);
endmodule

bind nmi_flag_unit nmi_flag_unit_chk #(
   .ADDR_W     (ADDR_W),
   .REG_OFS    (REG_OFS),
   .SRC_STRIDE (SRC_STRIDE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flag_word    (flag_word),
   .nmi_route    (nmi_route),
   .nmi_wake_en  (nmi_wake_en),
   .rstreq_route (rstreq_route),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .bus_err      (bus_err),
   .nmi_irq      (nmi_irq),
   .nmi_wake     (nmi_wake),
   .rstreq_irq   (rstreq_irq)
);

// File: tb/nmi_flag_unit_tb_top.sv
`timescale 1ns/1ps
module nmi_flag_unit_tb_top;
   localparam int ADDR_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nmi_pin = 1'b0;
   logic rstreq_in = 1'b0;
   logic [1:0] nmi_route = 2'b00;
   logic nmi_wake_en = 1'b1;
   logic [1:0] rstreq_route = 2'b00;
   logic rstreq_wake_en = 1'b1;
   logic bus_sel = 1'b0;
   logic bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic bus_err;
   logic nmi_irq, nmi_wake, rstreq_irq, rstreq_wake;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nmi_flag_unit dut_i (
      .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .rstreq_in(rstreq_in),
      .nmi_route(nmi_route), .nmi_wake_en(nmi_wake_en),
      .rstreq_route(rstreq_route), .rstreq_wake_en(rstreq_wake_en),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .nmi_irq(nmi_irq), .nmi_wake(nmi_wake),
      .rstreq_irq(rstreq_irq), .rstreq_wake(rstreq_wake)
   );

   // kind: 0 idle, 1 nmi edge, 2 reset-request edge, 3 write offset 0
   // fields: kind[2] data[32] cfg{nr[2],nw,rr[2],rw}[6] word[32] outs{ni,nw,ri,rw}[4] req[4]
   localparam int NV = 15;
   localparam logic [79:0] VEC [NV] = '{
      {2'd0, 32'h0,         6'b00_1_00_1, 32'h0000_0000, 4'b0000, 4'd1},  // R1
      {2'd1, 32'h0,         6'b00_1_00_1, 32'h0000_0001, 4'b1100, 4'd2},  // R2
      {2'd1, 32'h0,         6'b00_1_00_1, 32'h0000_0003, 4'b1100, 4'd3},  // R3
      {2'd3, 32'h0000_0001, 6'b00_1_00_1, 32'h0000_0002, 4'b1100, 4'd7},  // R7
      {2'd3, 32'h0000_0002, 6'b00_1_00_1, 32'h0000_0000, 4'b0000, 4'd4},  // R4
      {2'd1, 32'h0,         6'b11_0_00_1, 32'h0000_0001, 4'b0000, 4'd6},  // R6
      {2'd0, 32'h0,         6'b10_1_00_1, 32'h0000_0001, 4'b1100, 4'd6},  // R6
      {2'd0, 32'h0,         6'b11_1_00_1, 32'h0000_0001, 4'b0100, 4'd6},  // R6
      {2'd3, 32'h0000_0000, 6'b11_1_00_1, 32'h0000_0001, 4'b0100, 4'd4},  // R4
      {2'd3, 32'hFFFC_FFFC, 6'b11_1_00_1, 32'h0000_0001, 4'b0100, 4'd9},  // R9
      {2'd2, 32'h0,         6'b11_0_01_0, 32'h0001_0001, 4'b0010, 4'd8},  // R8
      {2'd2, 32'h0,         6'b11_0_01_0, 32'h0003_0001, 4'b0010, 4'd8},  // R8
      {2'd3, 32'h0001_0000, 6'b11_0_01_0, 32'h0002_0001, 4'b0010, 4'd8},  // R8
      {2'd0, 32'h0,         6'b11_0_11_1, 32'h0002_0001, 4'b0001, 4'd8},  // R8
      {2'd3, 32'hFFFF_FFFF, 6'b00_1_00_1, 32'h0000_0000, 4'b0000, 4'd4}   // R4
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata; e = bus_err;
      bus_sel = 1'b0;
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic nmi_edge();
      @(negedge clk); nmi_pin = 1'b1;
      repeat (5) @(negedge clk);
      nmi_pin = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic rq_edge();
      @(negedge clk); rstreq_in = 1'b1;
      @(negedge clk); rstreq_in = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [3:0] outs();
      return {nmi_irq, nmi_wake, rstreq_irq, rstreq_wake};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic e;
      string tag;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [79:0] v;
         v = VEC[i];
         {nmi_route, nmi_wake_en, rstreq_route, rstreq_wake_en} = v[45:40];
         case (v[79:78])
            2'd1: nmi_edge();
            2'd2: rq_edge();
            2'd3: wr(8'h00, v[77:46]);
            default: @(negedge clk);
         endcase
         rd(8'h00, d, e);
         tag = $sformatf("R%0d vec%0d word", v[3:0], i);
         chk(tag, d, v[39:8]);
         tag = $sformatf("R%0d vec%0d outs", v[3:0], i);
         chk(tag, {28'h0, outs()}, {28'h0, v[7:4]});
      end

      // R2: edge timing through the synchronizer, route 00
      nmi_route = 2'b00; nmi_wake_en = 1'b0;
      @(negedge clk); nmi_pin = 1'b1;
      @(negedge clk);
      @(negedge clk); #1;
      chk("R2 not yet after 2 edges", {31'h0, nmi_irq}, 32'h0);
      @(negedge clk); #1;
      chk("R2 set after 3 edges", {31'h0, nmi_irq}, 32'h1);
      repeat (10) @(negedge clk);
      rd(8'h00, d, e);
      chk("R2 held pin no overrun", d, 32'h0000_0001);
      nmi_pin = 1'b0;
      repeat (3) @(negedge clk);

      // R10: unmapped offset read and write
      rd(8'h04, d, e);
      chk("R10 err on read", {31'h0, e}, 32'h1);
      chk("R10 read data zero", d, 32'h0);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h00, d, e);
      chk("R10 write ignored", d, 32'h0000_0001);
      chk("R10 no err on hit", {31'h0, e}, 32'h0);

      // R5: event and clear in same cycle, first with flag clear, then set
      @(negedge clk);
      rstreq_in = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0001_0000;
      @(negedge clk);
      rstreq_in = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd(8'h00, d, e);
      chk("R5 set beats clear", d, 32'h0001_0001);
      @(negedge clk);
      rstreq_in = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0001_0000;
      @(negedge clk);
      rstreq_in = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd(8'h00, d, e);
      chk("R5 set beats clear with overrun", d, 32'h0003_0001);

      // R1: reset mid-run clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(8'h00, d, e);
      chk("R1 word after reset", d, 32'h0);
      chk("R1 outputs after reset", {28'h0, outs()}, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule